// File: doc/BRIEF.md
# OUT Endpoint Status and Handshake Controller

This block keeps the 8-bit control and status register of one receive (host-to-device) endpoint. It also picks the handshake that answers each data packet. The serial engine sends it pulses: an OUT token, and the end of a data packet together with that packet's PID parity, error flag, length and the packet buffer's full indication. A CPU reads and writes the register in a single cycle. At the end of every packet the block replies with a 2-bit handshake code, a store strobe to the packet buffer, and status updates in the register.

The block keeps the expected data toggle internally. In isochronous mode it accepts either data PID, sends no handshake, and records buffer overruns and corrupted packets in flags. A host that sends a packet longer than the maximum packet size causes a hardware stall that stays latched. When auto-clear is on, the packet-ready flag drops after the CPU has read one maximum-size packet out of the buffer.

Top module: `usb_out_ep_ctl`

## Requirements
- R1: After a synchronous reset the register reads 0x00, the expected toggle is DATA0, and hs_valid, buf_store, buf_flush and ovr_irq are low.
- R2: The register bits are: 0 ready, 1 overrun, 2 CPU stall, 3 isochronous, 4 forced stall, 5 data error, 6 flush, 7 auto-clear. Writing 0 to a flag bit (0, 1, 4, 5) clears it, and writing 1 to it leaves it unchanged. Bits 2, 3 and 7 read back the value written. Bit 6 always reads 0.
- R3: A write with bit 6 set drives buf_flush high in the following cycle, for exactly one cycle.
- R4: One cycle after pkt_end, hs_valid pulses with hs_code (0 none, 1 ACK, 2 NAK, 3 STALL). If bit 2 or bit 4 is set, the code is STALL, nothing is stored, and no other state changes.
- R5: A packet with pkt_len greater than MAXP sets bit 4 and is answered with STALL without being stored. A packet of exactly MAXP bytes is handled normally.
- R6: In non-isochronous mode, a good packet whose PID parity (pkt_pid1, 0 = DATA0) equals the expected toggle gets ACK when the buffer is not full. It is stored, sets bit 0, and flips the toggle.
- R7: In non-isochronous mode, a good packet with the wrong PID parity gets ACK, is not stored, and leaves the toggle and the flags unchanged.
- R8: In non-isochronous mode, a good packet that arrives while buf_full is high gets NAK and changes nothing.
- R9: A packet with pkt_bad set gets no handshake and is not stored. In isochronous mode it also sets bit 5.
- R10: In isochronous mode, a good packet of either PID parity gets no handshake, is stored and sets bit 0 unless buf_full is high, and leaves the toggle unchanged.
- R11: In isochronous mode, an OUT token that arrives while bit 0 is set sets bit 1, and ovr_irq follows bit 1.
- R12: A write of 1 to bit 3 followed by a write of 0 sets the expected toggle back to DATA0.
- R13: While bit 7 is set, bit 0 clears by itself on the MAXP-th rd_byte pulse counted since bit 0 last rose. While bit 7 is clear, bit 0 stays set.
- R14: When a hardware set and a CPU write of 0 hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_out | input | 1 | Pulse at the start of an OUT token for this endpoint |
| pkt_end | input | 1 | Pulse at the end of the data packet |
| pkt_bad | input | 1 | CRC or bit-stuffing error, valid with pkt_end |
| pkt_pid1 | input | 1 | Data PID parity (1 = DATA1), valid with pkt_end |
| pkt_len | input | LEN_W | Received byte count, valid with pkt_end |
| buf_full | input | 1 | Packet buffer cannot accept a packet |
| rd_byte | input | 1 | One byte unloaded from the packet buffer |
| reg_wr | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake code: 0 none, 1 ACK, 2 NAK, 3 STALL |
| buf_store | output | 1 | Commit the received packet to the buffer |
| buf_flush | output | 1 | One-cycle flush request to the buffer |
| ovr_irq | output | 1 | Overrun interrupt status |

## Verification
Most of this block's state appears at the port on the very next edge, because the register value is brought straight out on reg_rdata. The expected toggle is the exception: it never appears directly. An error in the toggle shows up only when the next non-isochronous packet arrives. That packet is either stored when it should be discarded, or discarded when it should be stored, and buf_store and bit 0 show this one cycle after pkt_end. A miscounted auto-clear shows as bit 0 dropping one read too early or too late. For that reason the bench checks bit 0 on both sides of the MAXP-th read.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_t;

    // register image, MSB first so that a cast gives the bus bit order
    typedef struct packed {
        logic auto_clr;
        logic flush;
        logic data_err;
        logic force_stall;
        logic iso;
        logic cpu_stall;
        logic overrun;
        logic ready;
    } csr_t;

    typedef struct packed {
        hs_code_t code;
        logic     store;
        logic     flip;
        logic     set_ready;
        logic     set_derr;
        logic     set_fstall;
    } verdict_t;

    // priority: stall > corrupted > isochronous > buffer full > toggle check
    function automatic verdict_t judge(
        input logic cpu_stall,
        input logic force_stall,
        input logic iso,
        input logic tog,
        input logic pid1,
        input logic bad,
        input logic full,
        input logic oversize
    );
        verdict_t v;
        v = '{code: HS_NONE, default: 1'b0};
        if (cpu_stall || force_stall || oversize) begin
            v.code       = HS_STALL;
            v.set_fstall = oversize;
        end else if (bad) begin
            v.set_derr = iso;
        end else if (iso) begin
            v.store     = !full;
            v.set_ready = !full;
        end else if (full) begin
            v.code = HS_NAK;
        end else begin
            v.code = HS_ACK;
            if (pid1 == tog) begin
                v.store     = 1'b1;
                v.set_ready = 1'b1;
                v.flip      = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ep_verdict.sv
module ep_verdict
    import usb_out_ep_pkg::*;
(
    input  logic     cpu_stall,
    input  logic     force_stall,
    input  logic     iso,
    input  logic     tog,
    input  logic     pid1,
    input  logic     bad,
    input  logic     full,
    input  logic     oversize,
    output verdict_t verdict
);
    always_comb begin
        verdict = judge(cpu_stall, force_stall, iso, tog, pid1, bad, full, oversize);
    end
endmodule

// File: rtl/ep_autoclr.sv
module ep_autoclr #(
    parameter int MAXP = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ready,
    input  logic rd_byte,
    output logic done
);
    localparam int CW = $clog2(MAXP + 1);
    localparam logic [CW-1:0] LAST = CW'(MAXP - 1);
    localparam logic [CW-1:0] CAP  = CW'(MAXP);

    logic [CW-1:0] cnt_q;

    assign done = enable && ready && rd_byte && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !ready || done) begin
            cnt_q <= '0;
        end else if (rd_byte && cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/usb_out_ep_ctl.sv
module usb_out_ep_ctl
    import usb_out_ep_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int MAXP  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_out,
    input  logic             pkt_end,
    input  logic             pkt_bad,
    input  logic             pkt_pid1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             buf_full,
    input  logic             rd_byte,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             buf_store,
    output logic             buf_flush,
    output logic             ovr_irq
);
    localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

    csr_t     csr_q, csr_d;
    logic     tog_q, tog_d;
    verdict_t v;
    logic     auto_done;
    csr_t     wr_img;

    assign wr_img = csr_t'(reg_wdata);

    ep_verdict u_verdict (
        .cpu_stall  (csr_q.cpu_stall),
        .force_stall(csr_q.force_stall),
        .iso        (csr_q.iso),
        .tog        (tog_q),
        .pid1       (pkt_pid1),
        .bad        (pkt_bad),
        .full       (buf_full),
        .oversize   (pkt_len > MAXP_L),
        .verdict    (v)
    );

    ep_autoclr #(.MAXP(MAXP)) u_autoclr (
        .clk    (clk),
        .rst    (rst),
        .enable (csr_q.auto_clr),
        .ready  (csr_q.ready),
        .rd_byte(rd_byte),
        .done   (auto_done)
    );

    always_comb begin
        csr_d       = csr_q;
        csr_d.flush = 1'b0;
        tog_d       = tog_q;
        // CPU side: control bits plain, flags cleared by a written zero
        if (reg_wr) begin
            csr_d.cpu_stall = wr_img.cpu_stall;
            csr_d.iso       = wr_img.iso;
            csr_d.auto_clr  = wr_img.auto_clr;
            if (!wr_img.ready)       csr_d.ready       = 1'b0;
            if (!wr_img.overrun)     csr_d.overrun     = 1'b0;
            if (!wr_img.force_stall) csr_d.force_stall = 1'b0;
            if (!wr_img.data_err)    csr_d.data_err    = 1'b0;
            if (csr_q.iso && !wr_img.iso) tog_d = 1'b0;
        end
        if (auto_done) csr_d.ready = 1'b0;
        // hardware sets come last so they win over a same-cycle clear
        if (pkt_end && v.set_ready)  csr_d.ready       = 1'b1;
        if (pkt_end && v.set_fstall) csr_d.force_stall = 1'b1;
        if (pkt_end && v.set_derr)   csr_d.data_err    = 1'b1;
        if (tok_out && csr_q.iso && csr_q.ready) csr_d.overrun = 1'b1;
        if (pkt_end && v.flip) tog_d = ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q     <= '0;
            tog_q     <= 1'b0;
            hs_valid  <= 1'b0;
            hs_code   <= HS_NONE;
            buf_store <= 1'b0;
            buf_flush <= 1'b0;
        end else begin
            csr_q     <= csr_d;
            tog_q     <= tog_d;
            hs_valid  <= pkt_end;
            hs_code   <= pkt_end ? v.code : HS_NONE;
            buf_store <= pkt_end && v.store;
            buf_flush <= reg_wr && wr_img.flush;
        end
    end

    assign reg_rdata = csr_q;
    assign ovr_irq   = csr_q.overrun;

endmodule

// File: rtl/ep_out_chk.sv
module ep_out_chk #(
    parameter int LEN_W = 11,
    parameter int MAXP  = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             tok_out,
    input logic             pkt_end,
    input logic             pkt_bad,
    input logic [LEN_W-1:0] pkt_len,
    input logic             buf_full,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             hs_valid,
    input logic [1:0]       hs_code,
    input logic             buf_store,
    input logic             buf_flush,
    input logic             ovr_irq
);
    localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == 8'h00) && !hs_valid && !buf_store && !buf_flush);

    // R3
    flush_req_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_wdata[6] |=> buf_flush);

    // R3
    flush_only_chk: assert property (@(posedge clk) disable iff (rst)
        buf_flush |-> $past(reg_wr && reg_wdata[6]));

    // R4
    stall_hs_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end && (reg_rdata[2] || reg_rdata[4]) |=>
            hs_valid && hs_code == 2'd3 && !buf_store);

    // R5
    oversize_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end && (pkt_len > MAXP_L) |=> reg_rdata[4] && hs_code == 2'd3);

    // R8
    nak_full_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end && buf_full && !pkt_bad && !reg_rdata[3] && !reg_rdata[2] &&
        !reg_rdata[4] && (pkt_len <= MAXP_L) |=> hs_code == 2'd2 && !buf_store);

    // R11
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        tok_out && reg_rdata[3] && reg_rdata[0] |=> reg_rdata[1] && ovr_irq);

    // R10 R14
    iso_store_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end && reg_rdata[3] && !pkt_bad && !buf_full && !reg_rdata[2] &&
        !reg_rdata[4] && (pkt_len <= MAXP_L) |=> reg_rdata[0] && buf_store && hs_code == 2'd0);
endmodule

bind usb_out_ep_ctl ep_out_chk #(.LEN_W(LEN_W), .MAXP(MAXP)) u_chk (
    .clk(clk), .rst(rst), .tok_out(tok_out), .pkt_end(pkt_end), .pkt_bad(pkt_bad),
    .pkt_len(pkt_len), .buf_full(buf_full), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hs_valid(hs_valid), .hs_code(hs_code),
    .buf_store(buf_store), .buf_flush(buf_flush), .ovr_irq(ovr_irq)
);

// File: tb/sim_usb_out_ep_ctl.sv
module sim_usb_out_ep_ctl;
    localparam int LEN_W = 11;
    localparam int MAXP  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tok_out = 1'b0, pkt_end = 1'b0, pkt_bad = 1'b0, pkt_pid1 = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             buf_full = 1'b0, rd_byte = 1'b0, reg_wr = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic             hs_valid, buf_store, buf_flush, ovr_irq;
    logic [1:0]       hs_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    usb_out_ep_ctl #(.LEN_W(LEN_W), .MAXP(MAXP)) u0 (
        .clk(clk), .rst(rst), .tok_out(tok_out), .pkt_end(pkt_end), .pkt_bad(pkt_bad),
        .pkt_pid1(pkt_pid1), .pkt_len(pkt_len), .buf_full(buf_full), .rd_byte(rd_byte),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hs_valid(hs_valid), .hs_code(hs_code), .buf_store(buf_store),
        .buf_flush(buf_flush), .ovr_irq(ovr_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pkt(input logic pid1, input logic bad, input logic full, input int len);
        pkt_end = 1'b1;
        pkt_pid1 = pid1;
        pkt_bad = bad;
        buf_full = full;
        pkt_len = LEN_W'(len);
        tick();
        pkt_end = 1'b0;
        pkt_bad = 1'b0;
        buf_full = 1'b0;
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            rd_byte = 1'b1;
            tick();
        end
        rd_byte = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 hs_valid", {7'd0, hs_valid}, 8'h00);
        chk("R1 store", {7'd0, buf_store}, 8'h00);
        chk("R1 flush", {7'd0, buf_flush}, 8'h00);
        chk("R1 irq", {7'd0, ovr_irq}, 8'h00);

        // R2 control bits read back, flags unaffected by ones, bit 6 reads 0
        wr(8'hFF);
        chk("R2 write ones", reg_rdata, 8'h8C);
        chk("R3 flush pulse", {7'd0, buf_flush}, 8'h01);
        tick();
        chk("R3 flush one cycle", {7'd0, buf_flush}, 8'h00);
        wr(8'h00);
        chk("R2 write zeros", reg_rdata, 8'h00);

        // R6 R7 R8 R9 R10 sweep over mode, PID, buffer full, error
        for (int c = 0; c < 16; c++) begin
            logic iso, pid, full, bad, exp_store;
            logic [1:0] exp_code;
            logic [7:0] exp_r;
            iso = c[3]; pid = c[2]; full = c[1]; bad = c[0];
            do_reset();
            if (iso) wr(8'h08);
            pkt(pid, bad, full, 4);
            exp_code  = (bad || iso) ? 2'd0 : (full ? 2'd2 : 2'd1);
            exp_store = !bad && !full && (iso || !pid);
            exp_r = (iso ? 8'h08 : 8'h00) | (exp_store ? 8'h01 : 8'h00) |
                    ((bad && iso) ? 8'h20 : 8'h00);
            chk("R6/R7/R8/R9/R10 hs_valid", {7'd0, hs_valid}, 8'h01);
            chk("R6/R7/R8/R9/R10 code", {6'd0, hs_code}, {6'd0, exp_code});
            chk("R6/R7/R8/R9/R10 store", {7'd0, buf_store}, {7'd0, exp_store});
            chk("R6/R7/R8/R9/R10 rdata", reg_rdata, exp_r);
        end

        // R6 toggle flips on store, R7 mismatch discarded
        do_reset();
        pkt(0, 0, 0, 4);
        chk("R6 store DATA0", {7'd0, buf_store}, 8'h01);
        wr(8'h00);
        pkt(0, 0, 0, 4);
        chk("R7 repeat DATA0 ack", {6'd0, hs_code}, 8'h01);
        chk("R7 repeat DATA0 dropped", {7'd0, buf_store}, 8'h00);
        chk("R7 flags unchanged", reg_rdata, 8'h00);
        pkt(1, 0, 0, 4);
        chk("R6 store DATA1", {7'd0, buf_store}, 8'h01);
        pkt(0, 0, 0, 4);
        chk("R6 store DATA0 again", {7'd0, buf_store}, 8'h01);

        // R12 toggle expected DATA1 now; pulse bit 3 to reset to DATA0
        wr(8'h08);
        wr(8'h00);
        pkt(1, 0, 0, 4);
        chk("R12 DATA1 dropped", {7'd0, buf_store}, 8'h00);
        pkt(0, 0, 0, 4);
        chk("R12 DATA0 stored", {7'd0, buf_store}, 8'h01);

        // R4 CPU stall
        do_reset();
        wr(8'h04);
        pkt(0, 0, 0, 4);
        chk("R4 stall code", {6'd0, hs_code}, 8'h03);
        chk("R4 stall no store", {7'd0, buf_store}, 8'h00);
        chk("R4 stall rdata", reg_rdata, 8'h04);
        pkt(0, 0, 1, 4);
        chk("R4 stall beats full", {6'd0, hs_code}, 8'h03);

        // R5 oversize forces stall
        do_reset();
        pkt(0, 0, 0, MAXP + 1);
        chk("R5 oversize code", {6'd0, hs_code}, 8'h03);
        chk("R5 oversize flag", reg_rdata, 8'h10);
        chk("R5 oversize no store", {7'd0, buf_store}, 8'h00);
        pkt(0, 0, 0, 4);
        chk("R5 latched stall", {6'd0, hs_code}, 8'h03);
        wr(8'h10);
        chk("R2 one leaves flag", reg_rdata, 8'h10);
        wr(8'h00);
        chk("R2 zero clears flag", reg_rdata, 8'h00);
        pkt(0, 0, 0, MAXP);
        chk("R5 exact max ack", {6'd0, hs_code}, 8'h01);
        chk("R5 exact max store", {7'd0, buf_store}, 8'h01);

        // R11 overrun in isochronous mode
        do_reset();
        wr(8'h08);
        pkt(1, 0, 0, 4);
        tok_out = 1'b1; tick(); tok_out = 1'b0;
        chk("R11 overrun flag", reg_rdata, 8'h0B);
        chk("R11 irq", {7'd0, ovr_irq}, 8'h01);
        wr(8'h09);
        chk("R11 overrun cleared", reg_rdata, 8'h09);
        chk("R11 irq cleared", {7'd0, ovr_irq}, 8'h00);
        do_reset();
        pkt(0, 0, 0, 4);
        tok_out = 1'b1; tick(); tok_out = 1'b0;
        chk("R11 no overrun non-iso", reg_rdata, 8'h01);

        // R13 auto clear after MAXP reads
        do_reset();
        wr(8'h80);
        pkt(0, 0, 0, MAXP);
        chk("R13 ready set", reg_rdata, 8'h81);
        rd(MAXP - 1);
        chk("R13 before last read", reg_rdata, 8'h81);
        rd(1);
        chk("R13 cleared on last read", reg_rdata, 8'h80);
        do_reset();
        pkt(0, 0, 0, MAXP);
        rd(MAXP + 2);
        chk("R13 disabled keeps ready", reg_rdata, 8'h01);

        // R14 hardware set beats same-cycle CPU clear
        do_reset();
        wr(8'h08);
        pkt(0, 0, 0, 4);
        reg_wr = 1'b1; reg_wdata = 8'h08;
        pkt_end = 1'b1; pkt_pid1 = 1'b1; pkt_len = LEN_W'(4);
        tick();
        reg_wr = 1'b0; pkt_end = 1'b0;
        chk("R14 ready set wins", reg_rdata, 8'h09);
        reg_wr = 1'b1; reg_wdata = 8'h09; tok_out = 1'b1;
        tick();
        reg_wr = 1'b0; tok_out = 1'b0;
        chk("R14 overrun set wins", reg_rdata, 8'h0B);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule